// File: doc/BRIEF.md
# Banked memory address decoder

This block sits between an 8-bit processor with a 16-bit address bus and a pair of external memories, one ROM and one RAM. During each memory cycle it enables exactly one of the two devices. It also forms the high address lines that reach past the processor's 64 KB reach, so the ROM spans 128 KB and the RAM spans 512 KB.

The processor sees four 16 KB regions:

| Range | Region |
|---|---|
| 0x0000-0x3FFF | fixed ROM |
| 0x4000-0x7FFF | switchable ROM |
| 0x8000-0xBFFF | fixed RAM |
| 0xC000-0xFFFF | switchable RAM |

Address bit 15 chooses the device. Address bit 14 chooses between the fixed window and the switchable window.

Which 16 KB page appears in each switchable window comes from an 8-bit page register. The processor loads this register through an active-low write strobe that an I/O decoder elsewhere produces. The low three bits pick the ROM page and the upper five bits pick the RAM page. While bit 14 is low, the extended lines read zero, so the fixed windows always reach page zero. The register keeps its value during that time, ready for the next access to a switchable window.

Top module: `bank_mem_decoder`

## Requirements
- R1: With `mreq_n` low and `addr[15]` high, `ram_ce_n` is low and `rom_ce_n` is high, in the same cycle (combinational).
- R2: With `mreq_n` low and `addr[15]` low, `rom_ce_n` is low and `ram_ce_n` is high, in the same cycle.
- R3: With `mreq_n` high, both `rom_ce_n` and `ram_ce_n` are high, whatever the address.
- R4: `rom_ce_n` and `ram_ce_n` are never low at the same time.
- R5: On a rising `clk` edge with `bank_wr_n` low, the page register takes `din`. On an edge with `bank_wr_n` high, it keeps its value.
- R6: `rst_n` low clears all eight page bits at once, without waiting for a clock edge.
- R7: With `addr[14]` low, `rom_addr[16:14]` and `ram_addr[18:14]` are all zero, whatever the register holds.
- R8: With `addr[14]` high, `rom_addr[16:14]` equals register bits 2:0 and `ram_addr[18:14]` equals register bits 7:3.
- R9: `rom_addr[13:0]` and `ram_addr[13:0]` both equal `addr[13:0]` at all times.
- R10: A page value written before a run of accesses with `addr[14]` low appears unchanged on the extended lines at the next access with `addr[14]` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the page register samples on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the page register |
| mreq_n | input | 1 | Active-low memory-cycle qualifier |
| bank_wr_n | input | 1 | Active-low page-register write strobe |
| addr | input | 16 | Processor address bus |
| din | input | 8 | Processor data bus, loaded into the page register |
| rom_ce_n | output | 1 | Active-low ROM enable |
| ram_ce_n | output | 1 | Active-low RAM enable |
| rom_addr | output | 17 | ROM address: page bits on 16:14, window offset on 13:0 |
| ram_addr | output | 19 | RAM address: page bits on 18:14, window offset on 13:0 |

## Verification
The clocked assertions compare combinational outputs with inputs as sampled at the rising edge. They therefore assume that `addr`, `mreq_n`, `bank_wr_n` and `din` are settled by that edge. The write-capture property also assumes that `din` is stable across the edge at which the strobe is low.

The bench changes every input only on the falling edge, so each value is stable for half a period on either side of the sampling edge. The random part chooses addresses over the full 16-bit space and places write strobes at random. Directed cases pin the window boundaries, a long run with `addr[14]` low, and a reset applied in the middle of a clock period.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;

  localparam int CPU_ADDR_W    = 16;
  localparam int PAGE_REG_W    = 8;
  localparam int ROM_PAGE_BITS = 3;
  localparam int RAM_PAGE_BITS = 5;
  localparam int WINDOW_BITS   = 14;

  typedef enum logic [1:0] {
    REG_ROM_FIXED = 2'b00,
    REG_ROM_SWAP  = 2'b01,
    REG_RAM_FIXED = 2'b10,
    REG_RAM_SWAP  = 2'b11
  } region_e;

  // Region from the two address bits above the window offset.
  function automatic region_e region_of(input logic [1:0] hi);
    region_e r;
    unique case (hi)
      2'b00:   r = REG_ROM_FIXED;
      2'b01:   r = REG_ROM_SWAP;
      2'b10:   r = REG_RAM_FIXED;
      default: r = REG_RAM_SWAP;
    endcase
    return r;
  endfunction

  function automatic logic region_is_ram(input region_e r);
    return (r == REG_RAM_FIXED) || (r == REG_RAM_SWAP);
  endfunction

  function automatic logic region_is_swap(input region_e r);
    return (r == REG_ROM_SWAP) || (r == REG_RAM_SWAP);
  endfunction

endpackage

// File: rtl/page_reg.sv
module page_reg #(
  parameter int WIDTH = bank_dec_pkg::PAGE_REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic load_ev;
  assign load_ev = !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load_ev) q <= d;
  end

  // R5: a strobe at one edge leaves the data word in the register after it
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (q == $past(d)));

  // R5: without a strobe the register holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(q));

endmodule

// File: rtl/chip_select.sv
module chip_select
  import bank_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mreq_n,
  input  logic [1:0] addr_hi,
  output logic       rom_ce_n,
  output logic       ram_ce_n
);

  region_e region;
  logic    want_ram;
  logic    cycle_on;

  assign region   = region_of(addr_hi);
  assign want_ram = region_is_ram(region);
  assign cycle_on = !mreq_n;

  always_comb begin
    rom_ce_n = 1'b1;
    ram_ce_n = 1'b1;
    if (cycle_on) begin
      if (want_ram) ram_ce_n = 1'b0;
      else          rom_ce_n = 1'b0;
    end
  end

  // R4: the two devices are never enabled together
  assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_ce_n && !ram_ce_n));

  // R3: no enable outside a memory cycle
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (rom_ce_n && ram_ce_n));

  // R1: the upper half of the map reaches RAM only
  assert_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && addr_hi[1]) |-> (!ram_ce_n && rom_ce_n));

  // R2: the lower half of the map reaches ROM only
  assert_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !addr_hi[1]) |-> (!rom_ce_n && ram_ce_n));

endmodule

// File: rtl/page_gate.sv
module page_gate #(
  parameter int BITS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            swap_win,
  input  logic [BITS-1:0] page,
  output logic [BITS-1:0] ext
);

  for (genvar i = 0; i < BITS; i++) begin : g_and
    assign ext[i] = page[i] & swap_win;
  end

  // R7: the fixed window forces every extended line to zero
  assert_fixed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_win |-> (ext == '0));

endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W   = CPU_ADDR_W,
  parameter int REG_W    = PAGE_REG_W,
  parameter int ROM_PB   = ROM_PAGE_BITS,
  parameter int RAM_PB   = RAM_PAGE_BITS,
  parameter int WIN_W    = WINDOW_BITS,
  localparam int ROM_AW  = WIN_W + ROM_PB,
  localparam int RAM_AW  = WIN_W + RAM_PB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_n,
  input  logic              bank_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  din,
  output logic              rom_ce_n,
  output logic              ram_ce_n,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr
);

  logic [REG_W-1:0]  page_q;
  logic [ROM_PB-1:0] rom_ext;
  logic [RAM_PB-1:0] ram_ext;
  logic              swap_win;

  assign swap_win = addr[WIN_W];

  page_reg #(.WIDTH(REG_W)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_n  (bank_wr_n),
    .d     (din),
    .q     (page_q)
  );

  chip_select u_cs (
    .clk      (clk),
    .rst_n    (rst_n),
    .mreq_n   (mreq_n),
    .addr_hi  (addr[ADDR_W-1:ADDR_W-2]),
    .rom_ce_n (rom_ce_n),
    .ram_ce_n (ram_ce_n)
  );

  page_gate #(.BITS(ROM_PB)) u_rom_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap_win (swap_win),
    .page     (page_q[ROM_PB-1:0]),
    .ext      (rom_ext)
  );

  page_gate #(.BITS(RAM_PB)) u_ram_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap_win (swap_win),
    .page     (page_q[ROM_PB +: RAM_PB]),
    .ext      (ram_ext)
  );

  assign rom_addr = {rom_ext, addr[WIN_W-1:0]};
  assign ram_addr = {ram_ext, addr[WIN_W-1:0]};

  // R8: switchable window shows the register slices
  assert_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_win |-> (rom_addr[ROM_AW-1:WIN_W] == page_q[ROM_PB-1:0]
               && ram_addr[RAM_AW-1:WIN_W] == page_q[ROM_PB +: RAM_PB]));

  // R9: offset inside the window passes to both devices
  assert_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_addr[WIN_W-1:0] == addr[WIN_W-1:0])
    && (ram_addr[WIN_W-1:0] == addr[WIN_W-1:0]));

  // R10: page value survives a fixed-window access
  assert_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!swap_win) && $past(bank_wr_n) && swap_win)
      |-> (rom_addr[ROM_AW-1:WIN_W] == $past(page_q[ROM_PB-1:0])));

endmodule

// File: tb/tb_bank_mem_decoder.sv
module tb_bank_mem_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mreq_n = 1'b1;
  logic        bank_wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic        rom_ce_n, ram_ce_n;
  logic [16:0] rom_addr;
  logic [18:0] ram_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;
  bit done = 1'b0;

  bank_mem_decoder dut (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .bank_wr_n(bank_wr_n),
    .addr(addr), .din(din), .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n),
    .rom_addr(rom_addr), .ram_addr(ram_addr)
  );

  always #2 clk = ~clk;

  // Expected page lines, written as a divide and modulo of the model.
  function automatic logic [2:0] exp_rom_page(input logic [7:0] m, input logic [15:0] a);
    int v;
    v = (a >= 16'h4000 && a < 16'h8000) || (a >= 16'hC000) ? int'(m) % 8 : 0;
    return v[2:0];
  endfunction

  function automatic logic [4:0] exp_ram_page(input logic [7:0] m, input logic [15:0] a);
    int v;
    v = (a >= 16'h4000 && a < 16'h8000) || (a >= 16'hC000) ? int'(m) / 8 : 0;
    return v[4:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr=0x%04h)", tag, act, exp, addr);
    end
  endtask

  task automatic check_all(input string page_tag);
    logic exp_rom, exp_ram;
    exp_rom = !(mreq_n == 1'b0 && addr < 16'h8000);
    exp_ram = !(mreq_n == 1'b0 && addr >= 16'h8000);
    if (mreq_n) begin
      chk("R3 rom_ce_n", 32'(rom_ce_n), 32'(exp_rom));
      chk("R3 ram_ce_n", 32'(ram_ce_n), 32'(exp_ram));
    end else if (addr[15]) begin
      chk("R1 rom_ce_n", 32'(rom_ce_n), 32'(exp_rom));
      chk("R1 ram_ce_n", 32'(ram_ce_n), 32'(exp_ram));
    end else begin
      chk("R2 rom_ce_n", 32'(rom_ce_n), 32'(exp_rom));
      chk("R2 ram_ce_n", 32'(ram_ce_n), 32'(exp_ram));
    end
    chk("R4 both enabled", 32'(!rom_ce_n && !ram_ce_n), 32'd0);
    chk("R9 rom offset", 32'(rom_addr[13:0]), 32'(addr % 16'h4000));
    chk("R9 ram offset", 32'(ram_addr[13:0]), 32'(addr % 16'h4000));
    chk({page_tag, " rom page"}, 32'(rom_addr[16:14]), 32'(exp_rom_page(model, addr)));
    chk({page_tag, " ram page"}, 32'(ram_addr[18:14]), 32'(exp_ram_page(model, addr)));
  endtask

  // One bus cycle: drive on the falling edge, check mid-phase, model the capture.
  task automatic cycle(input logic [15:0] a, input logic mq, input logic wr, input logic [7:0] d,
                       input string page_tag);
    @(negedge clk);
    addr = a; mreq_n = mq; bank_wr_n = wr; din = d;
    #1;
    check_all(page_tag);
    @(posedge clk);
    if (!wr) model = d;
  endtask

  function automatic string tag_for(input logic [15:0] a);
    return a[14] ? "R8" : "R7";
  endfunction

  initial begin
    logic [15:0] bounds [8];
    int unused_seed;
    unused_seed = $urandom(32'h0000_5EED);
    bounds = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF,
               16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};

    // Reset state: R6 and R3 while reset is held
    addr = 16'hC000; mreq_n = 1'b1;
    #3;
    chk("R6 rom page in reset", 32'(rom_addr[16:14]), 32'd0);
    chk("R6 ram page in reset", 32'(ram_addr[18:14]), 32'd0);
    chk("R3 rom_ce_n in reset", 32'(rom_ce_n), 32'd1);
    chk("R3 ram_ce_n in reset", 32'(ram_ce_n), 32'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: load a page value, then check every window boundary
    cycle(16'h0000, 1'b1, 1'b0, 8'b10101_011, "R7");
    for (int i = 0; i < 8; i++) cycle(bounds[i], 1'b0, 1'b1, 8'h00, tag_for(bounds[i]));
    for (int i = 0; i < 8; i++) cycle(bounds[i], 1'b1, 1'b1, 8'h00, tag_for(bounds[i]));
    cycle(16'h4123, 1'b0, 1'b0, 8'hFF, "R8");
    cycle(16'hC321, 1'b0, 1'b1, 8'h00, "R5");
    cycle(16'h4001, 1'b0, 1'b1, 8'h00, "R5");

    // R10: write a page value, run fixed-window accesses, then return
    cycle(16'h1000, 1'b0, 1'b0, 8'b01110_101, "R7");
    for (int i = 0; i < 20; i++) cycle(16'(i * 97) & 16'hBFFF, 1'b0, 1'b1, 8'h00, "R7");
    cycle(16'h5555, 1'b0, 1'b1, 8'h00, "R10");
    cycle(16'hD00D, 1'b0, 1'b1, 8'h00, "R10");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic mq, wr;
      a  = 16'($urandom);
      mq = ($urandom % 4) == 0;
      wr = ($urandom % 8) != 0;
      cycle(a, mq, wr, 8'($urandom), tag_for(a));
    end

    // R6: asynchronous clear in the middle of a clock phase
    cycle(16'h0000, 1'b1, 1'b0, 8'hFF, "R7");
    @(negedge clk);
    addr = 16'hC000; mreq_n = 1'b0; bank_wr_n = 1'b1;
    #1;
    rst_n = 1'b0;
    model = '0;
    #0.5;
    chk("R6 rom page after clear", 32'(rom_addr[16:14]), 32'd0);
    chk("R6 ram page after clear", 32'(ram_addr[18:14]), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(16'hFFFF, 1'b0, 1'b1, 8'h00, "R6");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule